// File: doc/BRIEF.md
# Programmable Gain Code Latch

This block is the digital control of a binary-step programmable gain amplifier. It takes a three-bit gain code and a gain-enable bit, and it passes them or keeps them depending on two interchangeable hold inputs. From the stored word it drives five one-hot gain-tap selects (gains 1, 2, 4, 8 and 16). It also reports the selected gain as a power-of-two exponent and raises a flag that tells the loop compensation to drop part of its capacitance at the two highest gains.

Every input is sampled on the rising edge of `clk`. While both hold inputs are low the stored word follows the inputs. Once either hold input is high the word is frozen until both are low again. A built-in timing watch checks the sampled inputs around each start of a hold period, using setup, hold and minimum-gap rules counted in clock cycles. It pulses an error output whenever one of those rules is broken.

Top module: `pga_gain_ctrl`

## Requirements
- R1: Transparent mode. When both `hold_a` and `hold_b` are low at a clock edge, the stored word takes the `code_in`/`gain_en` values sampled at that edge. The outputs reflect the new word right after that edge.
- R2: Hold mode. When `hold_a` or `hold_b` is high at an edge, the stored word keeps its value and changes on `code_in` or `gain_en` have no effect on the outputs. The two hold inputs behave identically.
- R3: A hold period keeps the word sampled at the last edge where both hold inputs were low. The first edge with both low again reloads the word from the inputs.
- R4: With the stored enable high, the stored code picks the gain. Code 000 gives exponent 0, code 001 gives 1, code 010 gives 2 and code 011 gives 3. Any code with bit 2 set gives exponent 4. `tap_sel` bit i is the tap for gain 2^i, and `gain_exp` equals i.
- R5: With the stored enable low, the gain is 1 (`gain_exp`=0, `tap_sel`=00001) whatever the code bits are.
- R6: Exactly one bit of `tap_sel` is high at every edge.
- R7: `bw_boost` is high exactly when the selected gain is 8 or 16 (exponent 3 or 4).
- R8: A synchronous reset (`rst` high at an edge) stores code 000 with enable low. This gives gain 1, `bw_boost` low and `timing_err` low.
- R9: Code setup. A hold start is an edge where the OR of the hold inputs is high after being low at the previous edge. At a hold start, the code sampled at that edge must equal the code sampled at each of the preceding CODE_SETUP edges (default 3). Otherwise `timing_err` is high right after that edge.
- R10: Code hold. The code must not change during the CODE_HOLD edges (default 3) that follow a hold start. A change at any of those edges raises `timing_err` right after it.
- R11: The enable bit follows the same setup and hold rules, with windows of EN_SETUP = 4 and EN_HOLD = 1 edges.
- R12: Two hold starts fewer than MIN_GAP edges apart (default 5) raise `timing_err` right after the second one. `timing_err` is low after every edge that breaks no rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 3 | Gain code |
| gain_en | input | 1 | Gain enable; low forces unity gain |
| hold_a | input | 1 | Hold control, high freezes the stored word |
| hold_b | input | 1 | Second hold control, same function as `hold_a` |
| tap_sel | output | 5 | One-hot gain-tap selects, bit i = gain 2^i |
| gain_exp | output | 3 | Selected gain as exponent (0..4) |
| bw_boost | output | 1 | Compensation reduction for gains 8 and 16 |
| timing_err | output | 1 | Pulses for one cycle after a setup, hold or gap violation |

## Verification
Two things can happen at the same edge: an input change that is ignored because a hold is active, and a hold-window violation caused by that same change. The bench drives a new code and enable one edge after a hold start. It then checks that the gain outputs still show the word captured before the hold, while `timing_err` pulses at that same edge. A second case combines a hold start that captures a fresh word with a setup failure. There the bench checks both the captured gain and the error pulse after that edge.

// File: rtl/pga_ctl_pkg.sv
package pga_ctl_pkg;

    localparam int CODE_W   = 3;
    localparam int NUM_TAPS = 5;
    localparam int EXP_W    = $clog2(NUM_TAPS);
    localparam int BOOST_EXP = 3;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              en;
    } gain_word_t;

    typedef logic [EXP_W-1:0] gain_exp_t;

    // Map a stored word to its gain exponent; the top code bit saturates.
    function automatic gain_exp_t word_to_exp(gain_word_t w);
        gain_exp_t e;
        if (!w.en)
            e = '0;
        else if (w.code[CODE_W-1])
            e = EXP_W'(NUM_TAPS - 1);
        else
            e = EXP_W'(w.code[CODE_W-2:0]);
        return e;
    endfunction

endpackage

// File: rtl/pga_code_store.sv
module pga_code_store
    import pga_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_a,
    input  logic       hold_b,
    input  gain_word_t d_in,
    output gain_word_t q
);

    logic frozen;
    assign frozen = hold_a | hold_b;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (!frozen)
            q <= d_in;
    end

    assert_hold_keeps_word_R2: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(q));

    assert_open_loads_word_R1: assert property (@(posedge clk) disable iff (rst)
        !frozen |=> (q == $past(d_in)));

endmodule

// File: rtl/pga_tap_decode.sv
module pga_tap_decode
    import pga_ctl_pkg::*;
(
    input  gain_word_t           w,
    output logic [NUM_TAPS-1:0]  tap_sel,
    output gain_exp_t            gain_exp,
    output logic                 bw_boost
);

    assign gain_exp = word_to_exp(w);
    assign bw_boost = (gain_exp >= EXP_W'(BOOST_EXP));

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_sel[i] = (gain_exp == EXP_W'(i));
    end

endmodule

// File: rtl/pga_timing_watch.sv
module pga_timing_watch #(
    parameter int W     = 3,
    parameter int SETUP = 3,
    parameter int HOLD  = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sample,
    input  logic         hold_start,
    output logic         viol
);

    localparam int RUN_MAX = SETUP + 1;
    localparam int CW      = $clog2(RUN_MAX + HOLD + 2);

    logic [W-1:0]  prv;
    logic [CW-1:0] run_len;
    logic [CW-1:0] hold_left;
    logic [CW-1:0] cur_run;
    logic          chg;

    assign chg     = (sample != prv);
    assign cur_run = chg ? CW'(1)
                   : ((run_len >= CW'(RUN_MAX)) ? CW'(RUN_MAX) : run_len + CW'(1));

    assign viol = (hold_start && (cur_run <= CW'(SETUP)))
               || ((hold_left != '0) && chg);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv       <= '0;
            run_len   <= CW'(RUN_MAX);
            hold_left <= '0;
        end else begin
            prv     <= sample;
            run_len <= cur_run;
            if (hold_start)
                hold_left <= CW'(HOLD);
            else if (hold_left != '0)
                hold_left <= hold_left - CW'(1);
        end
    end

    assert_hold_window_bound_R10: assert property (@(posedge clk) disable iff (rst)
        hold_left <= CW'(HOLD));

    assert_run_bound_R9: assert property (@(posedge clk) disable iff (rst)
        run_len <= CW'(RUN_MAX));

endmodule

// File: rtl/pga_edge_gap.sv
module pga_edge_gap #(
    parameter int MIN_GAP = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_any,
    output logic hold_start,
    output logic gap_viol
);

    localparam int GW = $clog2(MIN_GAP + 1) + 1;

    logic          prv_hold;
    logic [GW-1:0] since;

    assign hold_start = hold_any && !prv_hold;
    assign gap_viol   = hold_start && (since < GW'(MIN_GAP));

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_hold <= 1'b1;
            since    <= GW'(MIN_GAP);
        end else begin
            prv_hold <= hold_any;
            if (hold_start)
                since <= GW'(1);
            else if (since < GW'(MIN_GAP))
                since <= since + GW'(1);
        end
    end

    assert_gap_bound_R12: assert property (@(posedge clk) disable iff (rst)
        (since >= GW'(1)) && (since <= GW'(MIN_GAP)));

endmodule

// File: rtl/pga_gain_ctrl.sv
module pga_gain_ctrl
    import pga_ctl_pkg::*;
#(
    parameter int CODE_SETUP = 3,
    parameter int CODE_HOLD  = 3,
    parameter int EN_SETUP   = 4,
    parameter int EN_HOLD    = 1,
    parameter int MIN_GAP    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   code_in,
    input  logic                gain_en,
    input  logic                hold_a,
    input  logic                hold_b,
    output logic [NUM_TAPS-1:0] tap_sel,
    output logic [EXP_W-1:0]    gain_exp,
    output logic                bw_boost,
    output logic                timing_err
);

    gain_word_t d_word;
    gain_word_t s_word;
    logic       hold_start;
    logic       gap_viol;
    logic       code_viol;
    logic       en_viol;

    assign d_word.code = code_in;
    assign d_word.en   = gain_en;

    pga_code_store u_store (
        .clk    (clk),
        .rst    (rst),
        .hold_a (hold_a),
        .hold_b (hold_b),
        .d_in   (d_word),
        .q      (s_word)
    );

    pga_tap_decode u_dec (
        .w        (s_word),
        .tap_sel  (tap_sel),
        .gain_exp (gain_exp),
        .bw_boost (bw_boost)
    );

    pga_edge_gap #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .hold_any   (hold_a | hold_b),
        .hold_start (hold_start),
        .gap_viol   (gap_viol)
    );

    pga_timing_watch #(.W(CODE_W), .SETUP(CODE_SETUP), .HOLD(CODE_HOLD)) u_code_watch (
        .clk        (clk),
        .rst        (rst),
        .sample     (code_in),
        .hold_start (hold_start),
        .viol       (code_viol)
    );

    pga_timing_watch #(.W(1), .SETUP(EN_SETUP), .HOLD(EN_HOLD)) u_en_watch (
        .clk        (clk),
        .rst        (rst),
        .sample     (gain_en),
        .hold_start (hold_start),
        .viol       (en_viol)
    );

    always_ff @(posedge clk) begin
        if (rst)
            timing_err <= 1'b0;
        else
            timing_err <= code_viol | en_viol | gap_viol;
    end

    assert_single_tap_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1);

    assert_unity_when_off_R5: assert property (@(posedge clk) disable iff (rst)
        !s_word.en |-> (tap_sel[0] && gain_exp == '0));

    assert_boost_tracks_taps_R7: assert property (@(posedge clk) disable iff (rst)
        bw_boost == (tap_sel[NUM_TAPS-1] | tap_sel[NUM_TAPS-2]));

    assert_reset_unity_R8: assert property (@(posedge clk)
        rst |=> (gain_exp == '0 && !timing_err));

endmodule

// File: tb/pga_gain_ctrl_test.sv
`timescale 1ns/1ps
module pga_gain_ctrl_test;

    localparam real CLK_HALF = 5.0;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] code_in;
    logic       gain_en;
    logic       hold_a;
    logic       hold_b;
    logic [4:0] tap_sel;
    logic [2:0] gain_exp;
    logic       bw_boost;
    logic       timing_err;

    int total = 0;
    int bad   = 0;

    always #(CLK_HALF) clk = ~clk;

    pga_gain_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .code_in    (code_in),
        .gain_en    (gain_en),
        .hold_a     (hold_a),
        .hold_b     (hold_b),
        .tap_sel    (tap_sel),
        .gain_exp   (gain_exp),
        .bw_boost   (bw_boost),
        .timing_err (timing_err)
    );

    // row: {code[2:0], en, exp[2:0], boost}
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        {3'b000, 1'b1, 3'd0, 1'b0},
        {3'b001, 1'b1, 3'd1, 1'b0},
        {3'b010, 1'b1, 3'd2, 1'b0},
        {3'b011, 1'b1, 3'd3, 1'b1},
        {3'b100, 1'b1, 3'd4, 1'b1},
        {3'b101, 1'b1, 3'd4, 1'b1},
        {3'b110, 1'b1, 3'd4, 1'b1},
        {3'b111, 1'b1, 3'd4, 1'b1},
        {3'b111, 1'b0, 3'd0, 1'b0},
        {3'b011, 1'b0, 3'd0, 1'b0},
        {3'b100, 1'b0, 3'd0, 1'b0},
        {3'b010, 1'b1, 3'd2, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] c, input logic e, input logic a, input logic b);
        @(negedge clk);
        code_in = c;
        gain_en = e;
        hold_a  = a;
        hold_b  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic gain_is(input string tag, input int ex);
        chk({tag, " gain_exp"}, int'(gain_exp), ex);
        chk({tag, " tap_sel"}, int'(tap_sel), 1 << ex);
        chk({tag, " bw_boost"}, int'(bw_boost), (ex >= 3) ? 1 : 0);
    endtask

    task automatic settle(input logic [2:0] c, input logic e);
        for (int i = 0; i < 8; i++) apply(c, e, 1'b0, 1'b0);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; code_in = 3'b111; gain_en = 1'b1; hold_a = 1'b0; hold_b = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        gain_is("R8 reset", 0);
        chk("R8 reset timing_err", int'(timing_err), 0);
        @(negedge clk);
        rst = 1'b0;

        // R4 R5 R6 R7 R1: table walk in transparent mode
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][7:5], VEC[i][4], 1'b0, 1'b0);
            gain_is($sformatf("R4/R5/R7 row %0d", i), int'(VEC[i][3:1]));
            chk($sformatf("R6 row %0d onehot", i), $countones(tap_sel), 1);
            chk($sformatf("R1 row %0d timing_err", i), int'(timing_err), 0);
        end

        // R2/R10 same edge: ignored change plus hold violation
        settle(3'b010, 1'b1);
        apply(3'b010, 1'b1, 1'b1, 1'b0);
        gain_is("R2 hold start", 2);
        chk("R9 clean start", int'(timing_err), 0);
        apply(3'b101, 1'b0, 1'b1, 1'b0);
        gain_is("R2 ignored change", 2);
        chk("R10 hold violation", int'(timing_err), 1);
        apply(3'b101, 1'b0, 1'b1, 1'b0);
        chk("R10 no further change", int'(timing_err), 0);
        apply(3'b101, 1'b0, 1'b1, 1'b0);
        apply(3'b111, 1'b1, 1'b0, 1'b1);
        gain_is("R2 hold_b keeps word", 2);
        chk("R10 change after window", int'(timing_err), 0);
        apply(3'b111, 1'b1, 1'b0, 1'b0);
        gain_is("R3 release reloads", 4);

        // R9 setup violation with capture in same edge
        settle(3'b001, 1'b1);
        apply(3'b011, 1'b1, 1'b0, 1'b0);
        apply(3'b011, 1'b1, 1'b0, 1'b0);
        apply(3'b011, 1'b1, 1'b1, 1'b0);
        chk("R9 short setup", int'(timing_err), 1);
        gain_is("R3 captured word", 3);

        // R9 setup just met
        settle(3'b001, 1'b1);
        apply(3'b011, 1'b1, 1'b0, 1'b0);
        apply(3'b011, 1'b1, 1'b0, 1'b0);
        apply(3'b011, 1'b1, 1'b0, 1'b0);
        apply(3'b011, 1'b1, 1'b0, 1'b1);
        chk("R9 setup met", int'(timing_err), 0);

        // R11 enable setup violation
        settle(3'b000, 1'b1);
        apply(3'b000, 1'b0, 1'b0, 1'b0);
        apply(3'b000, 1'b0, 1'b0, 1'b0);
        apply(3'b000, 1'b0, 1'b0, 1'b0);
        apply(3'b000, 1'b0, 1'b1, 1'b0);
        chk("R11 enable short setup", int'(timing_err), 1);

        // R11 enable hold window of one edge
        settle(3'b010, 1'b1);
        apply(3'b010, 1'b1, 1'b1, 1'b0);
        chk("R11 clean start", int'(timing_err), 0);
        apply(3'b010, 1'b0, 1'b1, 1'b0);
        chk("R11 enable hold violation", int'(timing_err), 1);
        apply(3'b010, 1'b1, 1'b1, 1'b0);
        chk("R11 enable after window", int'(timing_err), 0);
        gain_is("R11 word kept", 2);

        // R12 minimum gap
        settle(3'b001, 1'b1);
        apply(3'b001, 1'b1, 1'b1, 1'b0);
        apply(3'b001, 1'b1, 1'b0, 1'b0);
        apply(3'b001, 1'b1, 1'b0, 1'b0);
        apply(3'b001, 1'b1, 1'b0, 1'b0);
        apply(3'b001, 1'b1, 1'b0, 1'b1);
        chk("R12 gap too short", int'(timing_err), 1);
        for (int i = 0; i < 4; i++) apply(3'b001, 1'b1, 1'b0, 1'b0);
        apply(3'b001, 1'b1, 1'b1, 1'b0);
        chk("R12 gap met", int'(timing_err), 0);

        // R8 reset while holding gain 16
        settle(3'b100, 1'b1);
        apply(3'b100, 1'b1, 1'b1, 1'b0);
        gain_is("R8 before reset", 4);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        gain_is("R8 reset during hold", 0);
        @(negedge clk);
        rst = 1'b0;
        apply(3'b100, 1'b1, 1'b1, 1'b0);
        gain_is("R2 hold after reset", 0);
        apply(3'b100, 1'b1, 1'b0, 1'b0);
        gain_is("R3 reload after reset", 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule